// File: doc/BRIEF.md
# Host-to-Controller Mailbox Register Block

This block is a memory-mapped doorbell and mailbox that sits between a host processor and an embedded controller. The host sees a 32-bit register bus over a 256-byte window. It writes a command word, which is latched and rung through to the controller as a one-cycle doorbell pulse. Before that it can load a source pointer, a destination pointer and a four-word outgoing data buffer. While the controller works, the block shows the host a busy flag. When the controller reports completion, the busy flag clears and an error flag and an 8-bit error code are captured. An interrupt pulse is raised if the command asked for one.

The controller side reads the latched command, both pointers and any word of the outgoing buffer. It fills a 16-byte response buffer one byte at a time. It signals completion with a done strobe that carries the error flag and the error code. The host learns the outcome by polling status until busy drops and then reading the error bit. When the command asked for an interrupt, the host can wait for the edge interrupt instead. That interrupt needs no acknowledgement.

Top module: `mbox_ipc_regs`

## Requirements
- R1: After reset the status word reads busy 0, error 0, command id 0 and error code 0, with the initiator id field (bits 15:8) equal to the INITIATOR_ID parameter. The interrupt and doorbell outputs are 0, and every response buffer word reads 0.
- R2: A host write to offset 0x00 while idle has three effects, all visible in the following cycle. The word appears on ctl_cmd. ctl_doorbell is high for exactly that one cycle. Status bit 0 (busy) reads 1.
- R3: Busy stays set until the controller pulses ctl_done. A ctl_done pulse while idle changes no status field and raises no interrupt.
- R4: A ctl_done pulse while busy has these effects in the next cycle:
  - busy reads 0;
  - status bit 1 equals ctl_err;
  - status bits 23:16 equal ctl_err_code;
  - status bits 7:4 equal bits 15:12 of the latched command.
  Status bits 3:2 and 31:24 always read 0.
- R5: host_irq is a single-cycle pulse in the cycle after a ctl_done pulse while busy, if and only if bit 8 of the latched command is 1.
- R6: Host writes to offset 0x08 load ctl_src_ptr, and host writes to offset 0x0C load ctl_dst_ptr.
- R7: A host write to offset 0x80 + 4k (k = 0..3) loads outgoing buffer word k, which the controller reads on ctl_wbuf_data when ctl_wbuf_sel = k.
- R8: Host writes to the command register, either pointer or the outgoing buffer while busy is set leave that storage unchanged and produce no doorbell.
- R9: Host reads return 0 at 0x00, 0x08, 0x0C, 0x80 to 0x8F, and at any offset outside the status register and the response buffer.
- R10: When ctl_rbuf_we is high, ctl_rbuf_byte is written to response byte ctl_rbuf_idx. A host read of 0x90 + 4k returns bytes 4k to 4k+3, with byte 4k in bits 7:0. Host writes to 0x90 to 0x9F have no effect.
- R11: Accepting a new command clears the status error bit and the error code. The command id field keeps its previous value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 8 | Host byte offset in the window |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational from hst_addr |
| ctl_doorbell | output | 1 | One-cycle pulse when a command is latched |
| ctl_cmd | output | 32 | Latched command word |
| ctl_src_ptr | output | 32 | Latched source pointer |
| ctl_dst_ptr | output | 32 | Latched destination pointer |
| ctl_wbuf_sel | input | 2 | Outgoing buffer word select |
| ctl_wbuf_data | output | 32 | Selected outgoing buffer word |
| ctl_rbuf_we | input | 1 | Response buffer byte write enable |
| ctl_rbuf_idx | input | 4 | Response buffer byte index |
| ctl_rbuf_byte | input | 8 | Response buffer byte data |
| ctl_done | input | 1 | Completion strobe from the controller |
| ctl_err | input | 1 | Error flag, sampled with ctl_done |
| ctl_err_code | input | 8 | Error code, sampled with ctl_done |
| host_irq | output | 1 | Completion interrupt pulse |

## Verification
The bench drives a second command and pointer and buffer writes into the busy window. A design missing the busy interlock would overwrite the running command and ring the doorbell again. It sends a completion strobe while idle, which a design that does not gate done with busy would turn into a spurious interrupt and a rewritten error code. It alternates failing and passing commands so that a stale error bit carried into the next command is caught. It also reads every write-only offset and the response buffer after a host write there, to expose leaked or host-writable storage.

// File: rtl/mbox_ipc_pkg.sv
package mbox_ipc_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned REGION_BYTES = 16;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_SRC  = 8'h08;
  localparam logic [7:0] OFS_DST  = 8'h0C;
  localparam logic [7:0] OFS_WBUF = 8'h80;
  localparam logic [7:0] OFS_RBUF = 8'h90;

  // True when the offset falls inside a 16-byte buffer region at base
  function automatic logic in_region(input logic [7:0] a, input logic [7:0] base);
    return (a >= base) && ({1'b0, a} < ({1'b0, base} + 9'(REGION_BYTES)));
  endfunction

  function automatic logic [3:0] cmd_id_of(input logic [31:0] c);
    return c[15:12];
  endfunction

  function automatic logic cmd_ioc_of(input logic [31:0] c);
    return c[8];
  endfunction

  function automatic logic [31:0] pack_status(input logic busy, input logic err,
                                               input logic [3:0] cid,
                                               input logic [7:0] init_id,
                                               input logic [7:0] code);
    return {8'h00, code, init_id, cid, 2'b00, err, busy};
  endfunction

endpackage

// File: rtl/mbox_ipc_hostregs.sv
module mbox_ipc_hostregs
  import mbox_ipc_pkg::*;
#(
  parameter int unsigned WBUF_WORDS = 4,
  localparam int unsigned WSEL_W = $clog2(WBUF_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [7:0]                   addr,
  input  logic [WORD_W-1:0]            wdata,
  input  logic                         busy,
  output logic [WORD_W-1:0]            cmd_q,
  output logic [WORD_W-1:0]            src_q,
  output logic [WORD_W-1:0]            dst_q,
  output logic [WBUF_WORDS*WORD_W-1:0] wbuf_flat,
  output logic                         cmd_accept,
  output logic                         doorbell
);

  // Every host write is gated by the busy interlock
  logic write_open;
  logic src_we;
  logic dst_we;
  logic wbuf_hit;
  logic [WSEL_W-1:0] wbuf_sel;

  assign write_open = wr && !busy;
  assign cmd_accept = write_open && (addr == OFS_CMD);
  assign src_we     = write_open && (addr == OFS_SRC);
  assign dst_we     = write_open && (addr == OFS_DST);
  assign wbuf_hit   = write_open && in_region(addr, OFS_WBUF);
  assign wbuf_sel   = addr[2 +: WSEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      doorbell <= 1'b0;
    end else begin
      doorbell <= cmd_accept;
      if (cmd_accept) cmd_q <= wdata;
      if (src_we)     src_q <= wdata;
      if (dst_we)     dst_q <= wdata;
    end
  end

  for (genvar g = 0; g < WBUF_WORDS; g++) begin : g_wbuf
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wbuf_hit && (wbuf_sel == WSEL_W'(g))) begin
        word_q <= wdata;
      end
    end
    assign wbuf_flat[g*WORD_W +: WORD_W] = word_q;
  end

  AST_DOORBELL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell); // R2
  AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q)); // R8
  AST_PTR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(src_q) && $stable(dst_q))); // R8

endmodule

// File: rtl/mbox_ipc_status.sv
module mbox_ipc_status
  import mbox_ipc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_accept,
  input  logic [WORD_W-1:0] cmd_q,
  input  logic              done,
  input  logic              done_err,
  input  logic [7:0]        done_code,
  output logic              busy,
  output logic              err,
  output logic [7:0]        err_code,
  output logic [3:0]        cid,
  output logic              irq,
  output logic              done_event
);

  // Completion only counts while a command is outstanding
  assign done_event = done && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
      cid      <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= done_event && cmd_ioc_of(cmd_q);
      if (cmd_accept) begin
        busy     <= 1'b1;
        err      <= 1'b0;
        err_code <= '0;
      end else if (done_event) begin
        busy     <= 1'b0;
        err      <= done_err;
        err_code <= done_code;
        cid      <= cmd_id_of(cmd_q);
      end
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy); // R2
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R3
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done_event |=> !busy); // R4
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(done_event)); // R5
  AST_ACCEPT_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> (!err && (err_code == 8'h00))); // R11

endmodule

// File: rtl/mbox_ipc_rbuf.sv
module mbox_ipc_rbuf
  import mbox_ipc_pkg::*;
#(
  parameter int unsigned RBUF_BYTES = 16,
  localparam int unsigned BIDX_W = $clog2(RBUF_BYTES),
  localparam int unsigned RSEL_W = BIDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BIDX_W-1:0] idx,
  input  logic [7:0]        wbyte,
  input  logic [RSEL_W-1:0] rd_sel,
  output logic [WORD_W-1:0] rd_word
);

  logic [7:0] mem [RBUF_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RBUF_BYTES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wbyte;
    end
  end

  // Little-endian gather of four bytes into one host word
  always_comb begin
    for (int b = 0; b < 4; b++) begin
      rd_word[8*b +: 8] = mem[{rd_sel, 2'(b)}];
    end
  end

endmodule

// File: rtl/mbox_ipc_regs.sv
module mbox_ipc_regs
  import mbox_ipc_pkg::*;
#(
  parameter int unsigned WBUF_WORDS   = 4,
  parameter int unsigned RBUF_BYTES   = 16,
  parameter logic [7:0]  INITIATOR_ID = 8'h01
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            hst_wr,
  input  logic [7:0]                      hst_addr,
  input  logic [31:0]                     hst_wdata,
  output logic [31:0]                     hst_rdata,
  output logic                            ctl_doorbell,
  output logic [31:0]                     ctl_cmd,
  output logic [31:0]                     ctl_src_ptr,
  output logic [31:0]                     ctl_dst_ptr,
  input  logic [$clog2(WBUF_WORDS)-1:0]   ctl_wbuf_sel,
  output logic [31:0]                     ctl_wbuf_data,
  input  logic                            ctl_rbuf_we,
  input  logic [$clog2(RBUF_BYTES)-1:0]   ctl_rbuf_idx,
  input  logic [7:0]                      ctl_rbuf_byte,
  input  logic                            ctl_done,
  input  logic                            ctl_err,
  input  logic [7:0]                      ctl_err_code,
  output logic                            host_irq
);

  localparam int unsigned RSEL_W = $clog2(RBUF_BYTES) - 2;

  logic                         busy;
  logic                         err;
  logic [7:0]                   err_code;
  logic [3:0]                   cid;
  logic                         cmd_accept;
  logic                         done_event;
  logic [WBUF_WORDS*WORD_W-1:0] wbuf_flat;
  logic [WORD_W-1:0]            rbuf_word;

  mbox_ipc_hostregs #(.WBUF_WORDS(WBUF_WORDS)) u_hostregs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (hst_wr),
    .addr       (hst_addr),
    .wdata      (hst_wdata),
    .busy       (busy),
    .cmd_q      (ctl_cmd),
    .src_q      (ctl_src_ptr),
    .dst_q      (ctl_dst_ptr),
    .wbuf_flat  (wbuf_flat),
    .cmd_accept (cmd_accept),
    .doorbell   (ctl_doorbell)
  );

  mbox_ipc_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_accept (cmd_accept),
    .cmd_q      (ctl_cmd),
    .done       (ctl_done),
    .done_err   (ctl_err),
    .done_code  (ctl_err_code),
    .busy       (busy),
    .err        (err),
    .err_code   (err_code),
    .cid        (cid),
    .irq        (host_irq),
    .done_event (done_event)
  );

  mbox_ipc_rbuf #(.RBUF_BYTES(RBUF_BYTES)) u_rbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctl_rbuf_we),
    .idx     (ctl_rbuf_idx),
    .wbyte   (ctl_rbuf_byte),
    .rd_sel  (hst_addr[2 +: RSEL_W]),
    .rd_word (rbuf_word)
  );

  assign ctl_wbuf_data = wbuf_flat[ctl_wbuf_sel*WORD_W +: WORD_W];

  // Only status and the response buffer are host-readable
  always_comb begin
    hst_rdata = '0;
    if (hst_addr == OFS_STAT) begin
      hst_rdata = pack_status(busy, err, cid, INITIATOR_ID, err_code);
    end else if (in_region(hst_addr, OFS_RBUF)) begin
      hst_rdata = rbuf_word;
    end
  end

  AST_NO_DOORBELL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_doorbell |-> $past(!busy)); // R8
  AST_IRQ_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> !busy); // R5

endmodule

// File: tb/mbox_ipc_regs_bench.sv
`timescale 1ns/1ps
module mbox_ipc_regs_bench;

  localparam logic [7:0] INIT = 8'h01;
  localparam int NV = 5;
  localparam logic [31:0] V_CMD  [NV] = '{32'h0003_11FF, 32'h0004_21FF, 32'h0000_F0F4,
                                          32'h0010_5105, 32'h0004_0102};
  localparam logic        V_ERR  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [7:0]  V_CODE [NV] = '{8'h00, 8'h5A, 8'h00, 8'hC3, 8'h7E};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr = 1'b0;
  logic [7:0]  hst_addr = 8'h00;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        ctl_doorbell;
  logic [31:0] ctl_cmd, ctl_src_ptr, ctl_dst_ptr, ctl_wbuf_data;
  logic [1:0]  ctl_wbuf_sel = '0;
  logic        ctl_rbuf_we = 1'b0;
  logic [3:0]  ctl_rbuf_idx = '0;
  logic [7:0]  ctl_rbuf_byte = '0;
  logic        ctl_done = 1'b0;
  logic        ctl_err = 1'b0;
  logic [7:0]  ctl_err_code = '0;
  logic        host_irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [3:0] last_cid = 4'h0;

  always #10 clk = ~clk;

  mbox_ipc_regs u_mbox_ipc_regs (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .ctl_doorbell(ctl_doorbell),
    .ctl_cmd(ctl_cmd), .ctl_src_ptr(ctl_src_ptr), .ctl_dst_ptr(ctl_dst_ptr),
    .ctl_wbuf_sel(ctl_wbuf_sel), .ctl_wbuf_data(ctl_wbuf_data),
    .ctl_rbuf_we(ctl_rbuf_we), .ctl_rbuf_idx(ctl_rbuf_idx),
    .ctl_rbuf_byte(ctl_rbuf_byte), .ctl_done(ctl_done), .ctl_err(ctl_err),
    .ctl_err_code(ctl_err_code), .host_irq(host_irq)
  );

  function automatic logic [31:0] stat_exp(input logic b, input logic e,
                                           input logic [3:0] id, input logic [7:0] code);
    return (32'(code) << 16) | (32'(INIT) << 8) | (32'(id) << 4) | (32'(e) << 1) | 32'(b);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge
  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
    hst_addr = a;
    #1;
    d = hst_rdata;
  endtask

  task automatic pulse_done(input logic e, input logic [7:0] code);
    ctl_done = 1'b1; ctl_err = e; ctl_err_code = code;
    @(negedge clk);
    ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held_cmd;
    repeat (3) @(negedge clk);
    // R1 reset state
    host_rd(8'h04, rd); chk("R1 status at reset", rd, stat_exp(0, 0, 4'h0, 8'h00));
    chk("R1 irq at reset", 32'(host_irq), 0);
    chk("R1 doorbell at reset", 32'(ctl_doorbell), 0);
    host_rd(8'h9C, rd); chk("R1 rbuf at reset", rd, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: command, completion, status and interrupt
    for (int i = 0; i < NV; i++) begin
      host_wr(8'h00, V_CMD[i]);
      chk("R2 doorbell pulse", 32'(ctl_doorbell), 1);
      chk("R2 latched cmd", ctl_cmd, V_CMD[i]);
      host_rd(8'h04, rd);
      chk("R11 busy status clears err", rd, stat_exp(1, 0, last_cid, 8'h00));
      @(negedge clk);
      chk("R2 doorbell single cycle", 32'(ctl_doorbell), 0);
      repeat (3) @(negedge clk);
      host_rd(8'h04, rd); chk("R3 busy held", 32'(rd[0]), 1);
      pulse_done(V_ERR[i], V_CODE[i]);
      last_cid = V_CMD[i][15:12];
      host_rd(8'h04, rd);
      chk("R4 status after done", rd, stat_exp(0, V_ERR[i], last_cid, V_CODE[i]));
      chk("R5 irq on done", 32'(host_irq), 32'(V_CMD[i][8]));
      @(negedge clk);
      chk("R5 irq single cycle", 32'(host_irq), 0);
    end

    // R3 done while idle is ignored
    pulse_done(1'b1, 8'hFF);
    host_rd(8'h04, rd); chk("R3 idle done ignored", rd, stat_exp(0, V_ERR[NV-1], last_cid, V_CODE[NV-1]));
    chk("R3 no irq idle done", 32'(host_irq), 0);

    // R6 pointers, R9 write-only reads
    host_wr(8'h08, 32'hA5A5_0001);
    host_wr(8'h0C, 32'h1234_5678);
    chk("R6 src ptr", ctl_src_ptr, 32'hA5A5_0001);
    chk("R6 dst ptr", ctl_dst_ptr, 32'h1234_5678);
    host_rd(8'h08, rd); chk("R9 src reads zero", rd, 0);
    host_rd(8'h0C, rd); chk("R9 dst reads zero", rd, 0);
    host_rd(8'h00, rd); chk("R9 cmd reads zero", rd, 0);

    // R7 outgoing buffer
    for (int k = 0; k < 4; k++) host_wr(8'h80 + 8'(4*k), 32'hB000_0000 + 32'(k));
    for (int k = 0; k < 4; k++) begin
      ctl_wbuf_sel = 2'(k); #1;
      chk("R7 wbuf word", ctl_wbuf_data, 32'hB000_0000 + 32'(k));
    end
    host_rd(8'h84, rd); chk("R9 wbuf reads zero", rd, 0);
    host_rd(8'h40, rd); chk("R9 unmapped reads zero", rd, 0);

    // R8 writes while busy are ignored
    host_wr(8'h00, 32'h0001_3000);
    held_cmd = 32'h0001_3000;
    @(negedge clk);
    host_wr(8'h00, 32'hDEAD_BEEF);
    chk("R8 no doorbell when busy", 32'(ctl_doorbell), 0);
    chk("R8 cmd held", ctl_cmd, held_cmd);
    host_wr(8'h08, 32'hFFFF_FFFF);
    host_wr(8'h0C, 32'hFFFF_FFFF);
    host_wr(8'h84, 32'hFFFF_FFFF);
    chk("R8 src held", ctl_src_ptr, 32'hA5A5_0001);
    chk("R8 dst held", ctl_dst_ptr, 32'h1234_5678);
    ctl_wbuf_sel = 2'd1; #1;
    chk("R8 wbuf held", ctl_wbuf_data, 32'hB000_0001);
    pulse_done(1'b0, 8'h00);
    last_cid = 4'h3;
    host_rd(8'h04, rd); chk("R4 cid of held cmd", rd, stat_exp(0, 0, 4'h3, 8'h00));

    // R10 response buffer
    for (int b = 0; b < 16; b++) begin
      ctl_rbuf_we = 1'b1; ctl_rbuf_idx = 4'(b); ctl_rbuf_byte = 8'h10 + 8'(b);
      @(negedge clk);
    end
    ctl_rbuf_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] e;
      for (int b = 0; b < 4; b++) e[8*b +: 8] = 8'h10 + 8'(4*k + b);
      host_rd(8'h90 + 8'(4*k), rd); chk("R10 rbuf word", rd, e);
    end
    host_wr(8'h94, 32'hFFFF_FFFF);
    host_rd(8'h94, rd); chk("R10 host write ignored", rd, 32'h1716_1514);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule